// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel Sequencer

This block is a single channel of a memory-to-memory copy engine. Software builds a linked list of 64-byte descriptors in memory and hands the channel the address of the first one with a start pulse. For each descriptor the channel reads the source buffer into a local copy buffer, writes that buffer to the destination, and can post a completion word to a fixed completion address. It then follows the next pointer until the chain ends.

Software can extend a chain that is already running. An append pulse makes the channel re-read the next-pointer slot of the last descriptor it fetched, either at once when idle or after the current descriptor when busy. A reset pulse stops the channel, but while a descriptor is in flight the stop waits until that descriptor has been completed. All memory traffic uses one 64-bit request/acknowledge port, one word per request.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset `busy` and `memReq` are 0, `statusWord` reads 3 (completed-descriptor field 0, transfer status 3) and both counters read 0.
- R2: A start pulse while idle sets the transfer status (`statusWord[1:0]`) to 0, raises `busy` on the next cycle and reads 8 words at `chainAddr`, `chainAddr+8`, ... Word roles: 0 control, 1 length in bytes, 2 source, 3 destination, 4 next pointer, 5 to 7 unused.
- R3: A valid descriptor copies ceil(length/8) words from source to destination in ascending order. When the destination write begins, `bytesCopied` grows by the length and `descCount` by 1.
- R4: After the last destination word, `statusWord[ADDR_W-1:6]` holds the descriptor address shifted right by 6 and bits 5:2 read 0. When control bit 1 is set, the 64-bit word `statusWord | 1` is then written to `cmplAddr`; otherwise nothing is written there.
- R5: A descriptor whose control bit 0 is set copies nothing, changes no counter and returns the channel to idle.
- R6: A descriptor with any control bit above bit 1 set, a zero length, or a length above `COPY_BUF_BYTES` copies nothing and returns to idle with `descErr` set. `descErr` stays set until the next start.
- R7: After a descriptor completes, the channel chooses in this order: a deferred reset goes idle, a nonzero next pointer fetches that descriptor, a pending append re-reads the next pointer, and otherwise the channel goes idle.
- R8: An append pulse while idle makes exactly one read, at the last descriptor address + 32. A zero result returns the channel to idle. A nonzero result fetches and runs that descriptor.
- R9: An append pulse while busy is held. If the current descriptor's next pointer is zero, the slot is re-read when the descriptor completes.
- R10: A reset pulse while idle sets the transfer status to 3 and the channel stays idle.
- R11: A reset pulse while busy lets the current descriptor finish its copy. The channel then goes idle with transfer status 3, without following the next pointer, and both held flags are cleared.
- R12: A start pulse while busy is ignored. When several pulses arrive together, start takes precedence over append, and append over reset.
- R13: While `memReq` is high and `memAck` is low, `memReq`, `memWe`, `memAddr` and `memWdata` hold steady. `memWe` is only high together with `memReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start pulse: run the chain at `chainAddr` |
| cmdAppend | input | 1 | Append pulse: re-read the last next pointer |
| cmdReset | input | 1 | Reset pulse: stop now or after the current descriptor |
| chainAddr | input | ADDR_W | First descriptor address, sampled on start |
| cmplAddr | input | ADDR_W | Address for completion words |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the 64-bit word |
| memWdata | output | 64 | Write data |
| memAck | input | 1 | Request accepted; read data valid in the same cycle |
| memRdata | input | 64 | Read data |
| busy | output | 1 | Channel is working through a chain |
| statusWord | output | ADDR_W | Completed-descriptor field [ADDR_W-1:6], transfer status [1:0] |
| bytesCopied | output | CNT_W | Running byte count |
| descCount | output | CNT_W | Running count of copied descriptors |
| descErr | output | 1 | Last descriptor was malformed |

## Verification
A command pulse is registered at the clock edge that samples it. `busy` and the transfer status therefore change one cycle later, and the bench reads them on the falling edge that follows its pulse task. Copy results, counters and the completion word only settle when the whole chain has ended, so the bench polls `busy` on falling edges and checks memory and counters only once `busy` is low. The memory model acknowledges every second cycle. The bench writes into memory during a run only after the descriptor fetch is over by a clear margin of cycles, so that the appended next pointer is seen by the re-read and not by the original fetch.

// File: rtl/desc_chain_dma_pkg.sv
package desc_chain_dma_pkg;
  localparam int WORD_BYTES    = 8;
  localparam int DESC_WORDS    = 8;
  localparam int NEXT_SLOT     = 4;
  localparam int FLAG_NULL_BIT = 0;
  localparam int FLAG_CMPL_BIT = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_NEXTPTR,
    ST_RD,
    ST_WR,
    ST_CMPL
  } seqState_t;

  typedef struct packed {
    logic loadChain;
    logic followNext;
    logic followMem;
    logic captureWord;
    logic bufWrite;
    logic idxClr;
    logic idxInc;
    logic markDone;
    logic bumpCount;
    logic setXfer0;
    logic setXfer3;
    logic setErr;
  } seqStrobe_t;
endpackage

// File: rtl/desc_chain_dma_ctrl.sv
module desc_chain_dma_ctrl
  import desc_chain_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdAppend,
  input  logic       cmdReset,
  input  logic       memAck,
  input  logic       idxLast,
  input  logic       flagNull,
  input  logic       flagCmpl,
  input  logic       descBad,
  input  logic       nextNonZero,
  input  logic       rdataZero,
  output seqState_t  state,
  output seqStrobe_t stb,
  output logic       memReq,
  output logic       memWe,
  output logic       busy
);
  seqState_t nextState;
  logic pendAppend, pendReset;
  logic doNext, clrAppend;

  assign busy   = (state != ST_IDLE);
  assign memReq = busy;
  assign memWe  = (state == ST_WR) || (state == ST_CMPL);

  always_comb begin
    stb       = '0;
    nextState = state;
    doNext    = 1'b0;
    clrAppend = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          stb.loadChain = 1'b1;
          stb.setXfer0  = 1'b1;
          stb.idxClr    = 1'b1;
          nextState     = ST_DESC;
        end else if (cmdAppend) begin
          nextState = ST_NEXTPTR;
        end else if (cmdReset) begin
          stb.setXfer3 = 1'b1;
        end
      end
      ST_DESC: begin
        if (memAck) begin
          stb.captureWord = 1'b1;
          stb.idxInc      = 1'b1;
          if (idxLast) begin
            stb.idxClr = 1'b1;
            if (flagNull) begin
              nextState = ST_IDLE;
            end else if (descBad) begin
              stb.setErr = 1'b1;
              nextState  = ST_IDLE;
            end else begin
              nextState = ST_RD;
            end
          end
        end
      end
      ST_NEXTPTR: begin
        if (memAck) begin
          if (rdataZero) begin
            nextState = ST_IDLE;
          end else begin
            stb.followMem = 1'b1;
            stb.idxClr    = 1'b1;
            nextState     = ST_DESC;
          end
        end
      end
      ST_RD: begin
        if (memAck) begin
          stb.bufWrite = 1'b1;
          stb.idxInc   = 1'b1;
          if (idxLast) begin
            stb.idxClr    = 1'b1;
            stb.bumpCount = 1'b1;
            nextState     = ST_WR;
          end
        end
      end
      ST_WR: begin
        if (memAck) begin
          stb.idxInc = 1'b1;
          if (idxLast) begin
            stb.idxClr   = 1'b1;
            stb.markDone = 1'b1;
            if (flagCmpl) nextState = ST_CMPL;
            else          doNext    = 1'b1;
          end
        end
      end
      ST_CMPL: begin
        if (memAck) doNext = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase

    if (doNext) begin
      if (pendReset) begin
        stb.setXfer3 = 1'b1;
        nextState    = ST_IDLE;
      end else if (nextNonZero) begin
        stb.followNext = 1'b1;
        nextState      = ST_DESC;
      end else if (pendAppend) begin
        clrAppend = 1'b1;
        nextState = ST_NEXTPTR;
      end else begin
        nextState = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pendAppend <= 1'b0;
      pendReset  <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.setXfer0 || (busy && nextState == ST_IDLE)) begin
        pendAppend <= 1'b0;
        pendReset  <= 1'b0;
      end
      if (clrAppend) pendAppend <= 1'b0;
      if (busy && !cmdStart) begin
        if (cmdAppend)     pendAppend <= 1'b1;
        else if (cmdReset) pendReset  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/desc_chain_dma_dpath.sv
module desc_chain_dma_dpath
  import desc_chain_dma_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int COPY_BUF_BYTES = 64,
  parameter int CNT_W          = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqState_t         state,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] chainAddr,
  input  logic [ADDR_W-1:0] cmplAddr,
  input  logic [63:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  output logic              idxLast,
  output logic              flagNull,
  output logic              flagCmpl,
  output logic              descBad,
  output logic              nextNonZero,
  output logic              rdataZero,
  output logic [ADDR_W-1:0] statusWord,
  output logic [CNT_W-1:0]  bytesCopied,
  output logic [CNT_W-1:0]  descCount,
  output logic              descErr
);
  localparam int BUF_WORDS = COPY_BUF_BYTES / WORD_BYTES;
  localparam int IDX_SPAN  = (BUF_WORDS > DESC_WORDS) ? BUF_WORDS : DESC_WORDS;
  localparam int IDX_W     = $clog2(IDX_SPAN);
  localparam int LEN_W     = IDX_W + 4;
  localparam logic [63:0] FLAG_MASK = (64'd1 << FLAG_NULL_BIT) | (64'd1 << FLAG_CMPL_BIT);
  localparam logic [ADDR_W-1:0] NEXT_OFF = ADDR_W'(NEXT_SLOT * WORD_BYTES);

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] descAddr, srcAddr, dstAddr, nextPtr, idxOff;
  logic [63:0]       descCtl, descLen;
  logic [1:0]        xferSt;
  logic [ADDR_W-7:0] complField;
  logic [LEN_W-1:0]  wordsNeed, lastWord;
  logic [63:0]       copyBuf [BUF_WORDS];

  assign idxOff      = {{(ADDR_W-IDX_W-3){1'b0}}, idx, 3'b000};
  assign flagNull    = descCtl[FLAG_NULL_BIT];
  assign flagCmpl    = descCtl[FLAG_CMPL_BIT];
  assign descBad     = (|(descCtl & ~FLAG_MASK)) || (descLen == 64'd0) ||
                       (descLen > 64'(COPY_BUF_BYTES));
  assign nextNonZero = (nextPtr != '0);
  assign rdataZero   = (memRdata[ADDR_W-1:0] == '0);
  assign wordsNeed   = (descLen[LEN_W-1:0] + LEN_W'(7)) >> 3;
  assign lastWord    = wordsNeed - LEN_W'(1);
  assign statusWord  = {complField, 4'b0000, xferSt};

  always_comb begin
    unique case (state)
      ST_DESC:        idxLast = (idx == IDX_W'(DESC_WORDS - 1));
      ST_RD, ST_WR:   idxLast = ({4'b0000, idx} == lastWord);
      default:        idxLast = 1'b0;
    endcase
  end

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    unique case (state)
      ST_DESC:    memAddr = descAddr + idxOff;
      ST_NEXTPTR: memAddr = descAddr + NEXT_OFF;
      ST_RD:      memAddr = srcAddr + idxOff;
      ST_WR: begin
        memAddr  = dstAddr + idxOff;
        memWdata = copyBuf[idx];
      end
      ST_CMPL: begin
        memAddr  = cmplAddr;
        memWdata = 64'(statusWord) | 64'd1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (stb.bufWrite) copyBuf[idx] <= memRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx         <= '0;
      descAddr    <= '0;
      srcAddr     <= '0;
      dstAddr     <= '0;
      nextPtr     <= '0;
      descCtl     <= '0;
      descLen     <= '0;
      xferSt      <= 2'd3;
      complField  <= '0;
      bytesCopied <= '0;
      descCount   <= '0;
      descErr     <= 1'b0;
    end else begin
      if (stb.idxClr)      idx <= '0;
      else if (stb.idxInc) idx <= idx + IDX_W'(1);
      if (stb.loadChain)  descAddr <= chainAddr;
      if (stb.followNext) descAddr <= nextPtr;
      if (stb.followMem)  descAddr <= memRdata[ADDR_W-1:0];
      if (stb.captureWord) begin
        unique case (idx)
          IDX_W'(0): descCtl <= memRdata;
          IDX_W'(1): descLen <= memRdata;
          IDX_W'(2): srcAddr <= memRdata[ADDR_W-1:0];
          IDX_W'(3): dstAddr <= memRdata[ADDR_W-1:0];
          IDX_W'(NEXT_SLOT): nextPtr <= memRdata[ADDR_W-1:0];
          default: ;
        endcase
      end
      if (stb.markDone) complField <= descAddr[ADDR_W-1:6];
      if (stb.bumpCount) begin
        bytesCopied <= bytesCopied + CNT_W'(descLen);
        descCount   <= descCount + CNT_W'(1);
      end
      if (stb.setXfer0) begin
        xferSt  <= 2'd0;
        descErr <= 1'b0;
      end
      if (stb.setXfer3) xferSt  <= 2'd3;
      if (stb.setErr)   descErr <= 1'b1;
    end
  end
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
  import desc_chain_dma_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int COPY_BUF_BYTES = 64,
  parameter int CNT_W          = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdAppend,
  input  logic              cmdReset,
  input  logic [ADDR_W-1:0] chainAddr,
  input  logic [ADDR_W-1:0] cmplAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  input  logic              memAck,
  input  logic [63:0]       memRdata,
  output logic              busy,
  output logic [ADDR_W-1:0] statusWord,
  output logic [CNT_W-1:0]  bytesCopied,
  output logic [CNT_W-1:0]  descCount,
  output logic              descErr
);
  seqState_t  state;
  seqStrobe_t stb;
  logic idxLast, flagNull, flagCmpl, descBad, nextNonZero, rdataZero;

  desc_chain_dma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdStart(cmdStart), .cmdAppend(cmdAppend), .cmdReset(cmdReset),
    .memAck(memAck), .idxLast(idxLast), .flagNull(flagNull),
    .flagCmpl(flagCmpl), .descBad(descBad), .nextNonZero(nextNonZero),
    .rdataZero(rdataZero), .state(state), .stb(stb),
    .memReq(memReq), .memWe(memWe), .busy(busy)
  );

  desc_chain_dma_dpath #(
    .ADDR_W(ADDR_W), .COPY_BUF_BYTES(COPY_BUF_BYTES), .CNT_W(CNT_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .state(state), .stb(stb),
    .chainAddr(chainAddr), .cmplAddr(cmplAddr), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .idxLast(idxLast),
    .flagNull(flagNull), .flagCmpl(flagCmpl), .descBad(descBad),
    .nextNonZero(nextNonZero), .rdataZero(rdataZero),
    .statusWord(statusWord), .bytesCopied(bytesCopied),
    .descCount(descCount), .descErr(descErr)
  );
endmodule

// File: rtl/desc_chain_dma_chk.sv
module desc_chain_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdStart,
  input logic              cmdAppend,
  input logic              cmdReset,
  input logic              busy,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [63:0]       memWdata,
  input logic [ADDR_W-1:0] statusWord,
  input logic [CNT_W-1:0]  descCount
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdStart) |=> (busy && statusWord[1:0] == 2'd0));

  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdReset && !cmdStart && !cmdAppend) |=> (!busy && statusWord[1:0] == 2'd3));

  p_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));

  p_we_req_r13: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (descCount != $past(descCount)) |-> (descCount == $past(descCount) + CNT_W'(1)));

  p_idle_status_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(statusWord[ADDR_W-1:2]));
endmodule

bind desc_chain_dma desc_chain_dma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdAppend(cmdAppend),
  .cmdReset(cmdReset), .busy(busy), .memReq(memReq), .memWe(memWe),
  .memAck(memAck), .memAddr(memAddr), .memWdata(memWdata),
  .statusWord(statusWord), .descCount(descCount)
);

// File: tb/desc_chain_dma_tb.sv
module desc_chain_dma_tb_top;
  typedef struct packed {
    logic [15:0] len;
    logic [7:0]  ctl;
    logic [7:0]  words;
    logic        err;
    logic        cmpl;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'd8,  8'h00, 8'd1, 1'b0, 1'b0},
    '{16'd24, 8'h02, 8'd3, 1'b0, 1'b1},
    '{16'd64, 8'h02, 8'd8, 1'b0, 1'b1},
    '{16'd13, 8'h00, 8'd2, 1'b0, 1'b0},
    '{16'd65, 8'h00, 8'd0, 1'b1, 1'b0},
    '{16'd16, 8'h04, 8'd0, 1'b1, 1'b0},
    '{16'd16, 8'h01, 8'd0, 1'b0, 1'b0},
    '{16'd0,  8'h00, 8'd0, 1'b1, 1'b0}
  };
  localparam logic [63:0] MARK = 64'hDEAD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0, cmdAppend = 1'b0, cmdReset = 1'b0;
  logic [31:0] chainAddr = 32'h100;
  logic [31:0] cmplAddr  = 32'h400;
  logic memReq, memWe, memAck = 1'b0, busy, descErr;
  logic [31:0] memAddr, statusWord, bytesCopied, descCount;
  logic [63:0] memWdata, memRdata = '0;
  logic [63:0] mem [256];
  int testCnt = 0, failCnt = 0, ackCnt = 0;

  always #5 clk = ~clk;

  desc_chain_dma dut_i (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdAppend(cmdAppend),
    .cmdReset(cmdReset), .chainAddr(chainAddr), .cmplAddr(cmplAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .busy(busy), .statusWord(statusWord),
    .bytesCopied(bytesCopied), .descCount(descCount), .descErr(descErr)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        memAck = 1'b1;
        ackCnt++;
        if (memWe) mem[memAddr[10:3]] = memWdata;
        else       memRdata = mem[memAddr[10:3]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit s, input bit a, input bit r);
    @(negedge clk);
    cmdStart = s; cmdAppend = a; cmdReset = r;
    @(negedge clk);
    cmdStart = 1'b0; cmdAppend = 1'b0; cmdReset = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    @(negedge clk);
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (busy) chk(1'b0, req, 64'(busy), 64'd0);
  endtask

  task automatic putDesc(input int b, input logic [63:0] ctl, len, src, dst, nxt);
    mem[b] = ctl; mem[b+1] = len; mem[b+2] = src; mem[b+3] = dst; mem[b+4] = nxt;
    mem[b+5] = '0; mem[b+6] = '0; mem[b+7] = '0;
  endtask

  initial begin
    #2_000_000;
    failCnt++;
    $display("FAIL R13 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] b0, d0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !memReq, "R1 idle after reset", {memReq, busy}, 0);
    chk(statusWord == 32'd3, "R1 status after reset", statusWord, 3);
    chk(bytesCopied == 0 && descCount == 0, "R1 counters", {bytesCopied, descCount}, 0);

    // table of single descriptors: R2 R3 R4 R5 R6 R13
    for (int v = 0; v < 8; v++) begin
      bit ok;
      for (int k = 0; k < 8; k++) begin
        mem[64+k] = 64'hA000 + 64'(v * 16 + k);
        mem[96+k] = '0;
      end
      mem[128] = MARK;
      putDesc(32, 64'(VEC[v].ctl), 64'(VEC[v].len), 64'h200, 64'h300, 64'h0);
      chainAddr = 32'h100;
      b0 = bytesCopied; d0 = descCount;
      pulse(1'b1, 1'b0, 1'b0);
      waitIdle("R2 run ends");
      ok = 1'b1;
      for (int k = 0; k < 8; k++)
        if (mem[96+k] != ((k < int'(VEC[v].words)) ? mem[64+k] : 64'h0)) ok = 1'b0;
      chk(ok, $sformatf("R3 R5 R13 copy vec %0d", v), mem[96], (VEC[v].words != 0) ? mem[64] : 64'h0);
      chk(bytesCopied - b0 == ((VEC[v].words != 0) ? 32'(VEC[v].len) : 32'd0),
          $sformatf("R3 byte count vec %0d", v), bytesCopied - b0, 64'(VEC[v].len));
      chk(descCount - d0 == ((VEC[v].words != 0) ? 32'd1 : 32'd0),
          $sformatf("R3 R5 desc count vec %0d", v), descCount - d0, 64'(VEC[v].words != 0));
      chk(descErr == VEC[v].err, $sformatf("R6 error flag vec %0d", v), 64'(descErr), 64'(VEC[v].err));
      chk(mem[128] == (VEC[v].cmpl ? 64'h101 : MARK), $sformatf("R4 completion word vec %0d", v),
          mem[128], VEC[v].cmpl ? 64'h101 : MARK);
      if (VEC[v].words != 0)
        chk(statusWord == 32'h100, $sformatf("R4 status field vec %0d", v), statusWord, 64'h100);
    end

    // R7 two-descriptor chain
    putDesc(32, 64'h0, 64'd16, 64'h200, 64'h300, 64'h140);
    putDesc(40, 64'h2, 64'd8, 64'h240, 64'h340, 64'h0);
    mem[64] = 64'h1111; mem[65] = 64'h2222; mem[72] = 64'h3333;
    mem[96] = '0; mem[97] = '0; mem[104] = '0; mem[128] = MARK;
    d0 = descCount;
    pulse(1'b1, 1'b0, 1'b0);
    waitIdle("R7 chain ends");
    chk(mem[96] == 64'h1111 && mem[97] == 64'h2222 && mem[104] == 64'h3333,
        "R7 both descriptors copied", mem[104], 64'h3333);
    chk(descCount - d0 == 2, "R7 desc count", descCount - d0, 2);
    chk(mem[128] == 64'h141 && statusWord == 32'h140, "R4 R7 completion of second", mem[128], 64'h141);

    // R8 append while idle, zero pointer then nonzero
    b0 = ackCnt; d0 = descCount;
    pulse(1'b0, 1'b1, 1'b0);
    waitIdle("R8 append zero ends");
    chk(ackCnt - b0 == 1, "R8 single pointer read", ackCnt - b0, 1);
    chk(descCount == d0 && statusWord == 32'h140, "R8 nothing run", descCount, d0);
    mem[44] = 64'h180;
    putDesc(48, 64'h2, 64'd8, 64'h280, 64'h380, 64'h0);
    mem[80] = 64'h4444; mem[112] = '0; mem[128] = MARK;
    pulse(1'b0, 1'b1, 1'b0);
    waitIdle("R8 append run ends");
    chk(mem[112] == 64'h4444 && mem[128] == 64'h181, "R8 appended descriptor run", mem[128], 64'h181);

    // R9 append while busy
    putDesc(32, 64'h0, 64'd64, 64'h200, 64'h300, 64'h0);
    putDesc(56, 64'h0, 64'd8, 64'h2C0, 64'h3C0, 64'h0);
    mem[88] = 64'h5555; mem[120] = '0;
    d0 = descCount;
    pulse(1'b1, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    mem[36] = 64'h1C0;
    pulse(1'b0, 1'b1, 1'b0);
    waitIdle("R9 run ends");
    chk(mem[120] == 64'h5555, "R9 re-read pointer followed", mem[120], 64'h5555);
    chk(descCount - d0 == 2, "R9 desc count", descCount - d0, 2);

    // R11 reset while busy
    putDesc(32, 64'h0, 64'd8, 64'h200, 64'h300, 64'h140);
    putDesc(40, 64'h0, 64'd8, 64'h240, 64'h340, 64'h0);
    mem[64] = 64'h6666; mem[96] = '0; mem[104] = '0;
    d0 = descCount;
    pulse(1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    pulse(1'b0, 1'b0, 1'b1);
    waitIdle("R11 run ends");
    chk(mem[96] == 64'h6666, "R11 current descriptor finished", mem[96], 64'h6666);
    chk(mem[104] == 64'h0 && descCount - d0 == 1, "R11 next not followed", mem[104], 0);
    chk(statusWord[1:0] == 2'd3, "R11 status 3", 64'(statusWord[1:0]), 3);

    // R10 reset while idle after a normal run
    putDesc(32, 64'h0, 64'd8, 64'h200, 64'h300, 64'h0);
    pulse(1'b1, 1'b0, 1'b0);
    chk(busy && statusWord[1:0] == 2'd0, "R2 status 0 after start", 64'(statusWord[1:0]), 0);
    waitIdle("R10 run ends");
    pulse(1'b0, 1'b0, 1'b1);
    chk(!busy && statusWord[1:0] == 2'd3, "R10 idle reset", 64'(statusWord[1:0]), 3);

    // R12 start while busy ignored, then priority
    mem[104] = '0;
    d0 = descCount;
    chainAddr = 32'h100;
    pulse(1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chainAddr = 32'h140;
    pulse(1'b1, 1'b0, 1'b0);
    waitIdle("R12 run ends");
    chk(descCount - d0 == 1 && mem[104] == 64'h0, "R12 second start ignored", descCount - d0, 1);
    chainAddr = 32'h100;
    pulse(1'b1, 1'b0, 1'b1);
    chk(busy && statusWord[1:0] == 2'd0, "R12 start beats reset", 64'(statusWord[1:0]), 0);
    waitIdle("R12 priority run ends");

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule